// File: doc/BRIEF.md
# Configurable Multi-Mode I/O Port

This block is one I/O port of a microcontroller-based device. A byte-wide register bus from the processor sets three things for each pin: whether its output value comes from the processor's data latch or from a bit of the internal address bus; whether the pin drives or receives; and how the pad driver behaves, either open-drain or push-pull, or fast or slow slew on pins that have slew control instead of open-drain.

A pin drives when its software direction bit is set or when a per-pin output-enable term from the programmable logic is active. Parameters select the port variant. A full variant carries the mode register and honours the logic output-enable. A reduced two-pin variant has no mode register and takes its direction from software alone. The pad's current level is brought back through a two-stage synchroniser and can be read on the register bus.

Top module: `cfgIoPort`

## Requirements
- R1: After reset the mode, direction, drive and data registers are all 0: every pin is an input in processor-data mode with push-pull, slow-slew drive, so padOe, padOut, openDrain and fastSlew are all 0 while pldOe is low.
- R2: A write takes effect at the clock edge where regSel and regWr are both high. regAddr picks the register: 0 mode, 1 direction, 2 drive, 3 data latch or pin state. Reads are combinational. The mode, direction and drive registers read back their contents. regRdata is 0 whenever regSel is low, and bits at or above WIDTH always read 0.
- R3: Bit i of each register controls pin i only. In push-pull drive, padOe[i] is direction[i] OR pldOe[i]. For example, direction 0x07 makes pins 0 to 2 outputs.
- R4: When HAS_CTRL is 0, the mode register does not exist. Writes to offset 0 are ignored, reads of offset 0 return 0, and every pin stays in processor-data mode.
- R5: When USE_PLD_OE is 0, pldOe has no effect, and the direction register alone sets padOe.
- R6: padOut[i] is addrBus[i] when mode bit i is 1, and data-latch bit i when mode bit i is 0.
- R7: Drive bit i at 1 sets openDrain[i] when bit i of OD_MASK is 1, and sets fastSlew[i] when that bit is 0. A drive bit at 0 means push-pull or slow slew. openDrain and fastSlew are never both high on one pin.
- R8: On a pin in open-drain drive, padOe is high only when the pin is an output and padOut is 0. A driven 1 releases the pad.
- R9: A read of offset 3 returns the value padIn had two clock edges earlier, passed through a two-stage synchroniser that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access select for this port |
| regAddr | input | 2 | Register offset |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data |
| addrBus | input | WIDTH | Internal address bits used in address-out mode |
| pldOe | input | WIDTH | Per-pin output-enable term from programmable logic |
| padIn | input | WIDTH | Pad input levels |
| padOut | output | WIDTH | Pad output value |
| padOe | output | WIDTH | Pad output enable |
| openDrain | output | WIDTH | Pad set to open-drain drive |
| fastSlew | output | WIDTH | Pad set to fast slew |

## Verification
The bench runs a full port and a reduced port side by side and compares both against a behavioural model on every clock. A design that ignored the logic output-enable, or let the reduced port use it, would show the wrong padOe. A design that drove the pad for an open-drain 1 would also show the wrong padOe. A mode register that wrongly exists in the reduced variant would read back a nonzero value. Reads of pin state are checked against a delayed input history, so a synchroniser of the wrong depth shows up as a one-cycle shift. Pins in mixed modes (some address-out, some processor data) check that each bit selects its own source.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    OFS_MODE = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_DRV  = 2'd2,
    OFS_PIN  = 2'd3
  } regOfs_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrDir;
    logic    wrDrv;
    logic    wrData;
    logic    rdEn;
    regOfs_e rdSel;
  } ioStrobe_t;
endpackage

// File: rtl/cfgIoCtrl.sv
module cfgIoCtrl
  import cfgio_pkg::*;
(
  input  logic       regSel,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  output ioStrobe_t  strobe
);
  regOfs_e ofs;

  assign ofs = regOfs_e'(regAddr);

  always_comb begin
    strobe       = '0;
    strobe.rdEn  = regSel;
    strobe.rdSel = ofs;
    if (regSel && regWr) begin
      unique case (ofs)
        OFS_MODE: strobe.wrMode = 1'b1;
        OFS_DIR:  strobe.wrDir  = 1'b1;
        OFS_DRV:  strobe.wrDrv  = 1'b1;
        OFS_PIN:  strobe.wrData = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cfgIoDatapath.sv
module cfgIoDatapath
  import cfgio_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter bit               HAS_CTRL    = 1'b1,
  parameter bit               USE_PLD_OE  = 1'b1,
  parameter logic [BUS_W-1:0] OD_MASK     = 8'h0F,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ioStrobe_t        strobe,
  input  logic [BUS_W-1:0] regWdata,
  input  logic [WIDTH-1:0] addrBus,
  input  logic [WIDTH-1:0] pldOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [BUS_W-1:0] regRdata,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] openDrain,
  output logic [WIDTH-1:0] fastSlew
);
  logic [WIDTH-1:0] modeQ, dirQ, drvQ, dataQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] wantOut;
  logic [WIDTH-1:0] rdVal;

  generate
    if (HAS_CTRL) begin : g_mode
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              modeQ <= '0;
        else if (strobe.wrMode) modeQ <= regWdata[WIDTH-1:0];
      end
    end else begin : g_noMode
      assign modeQ = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      drvQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.wrDir)  dirQ  <= regWdata[WIDTH-1:0];
      if (strobe.wrDrv)  drvQ  <= regWdata[WIDTH-1:0];
      if (strobe.wrData) dataQ <= regWdata[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  generate
    if (USE_PLD_OE) begin : g_pldOe
      assign wantOut = dirQ | pldOe;
    end else begin : g_swOe
      assign wantOut = dirQ;
    end
  endgenerate

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign padOut[i] = modeQ[i] ? addrBus[i] : dataQ[i];
    if (OD_MASK[i]) begin : g_od
      assign openDrain[i] = drvQ[i];
      assign fastSlew[i]  = 1'b0;
      assign padOe[i]     = wantOut[i] & ~(drvQ[i] & padOut[i]);
    end else begin : g_slew
      assign openDrain[i] = 1'b0;
      assign fastSlew[i]  = drvQ[i];
      assign padOe[i]     = wantOut[i];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      OFS_MODE: rdVal = modeQ;
      OFS_DIR:  rdVal = dirQ;
      OFS_DRV:  rdVal = drvQ;
      OFS_PIN:  rdVal = syncQ[SYNC_STAGES-1];
    endcase
    regRdata = '0;
    if (strobe.rdEn) regRdata[WIDTH-1:0] = rdVal;
  end
endmodule

// File: rtl/cfgIoPort.sv
module cfgIoPort
  import cfgio_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter bit               HAS_CTRL   = 1'b1,
  parameter bit               USE_PLD_OE = 1'b1,
  parameter logic [BUS_W-1:0] OD_MASK    = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic [WIDTH-1:0] addrBus,
  input  logic [WIDTH-1:0] pldOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] openDrain,
  output logic [WIDTH-1:0] fastSlew
);
  ioStrobe_t strobe;

  cfgIoCtrl i_ctrl (
    .regSel (regSel),
    .regAddr(regAddr),
    .regWr  (regWr),
    .strobe (strobe)
  );

  cfgIoDatapath #(
    .WIDTH      (WIDTH),
    .HAS_CTRL   (HAS_CTRL),
    .USE_PLD_OE (USE_PLD_OE),
    .OD_MASK    (OD_MASK),
    .SYNC_STAGES(2)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .addrBus  (addrBus),
    .pldOe    (pldOe),
    .padIn    (padIn),
    .regRdata (regRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .openDrain(openDrain),
    .fastSlew (fastSlew)
  );
endmodule

// File: rtl/cfgIoPortChk.sv
module cfgIoPortChk #(
  parameter int         WIDTH      = 8,
  parameter bit         HAS_CTRL   = 1'b1,
  parameter bit         USE_PLD_OE = 1'b1,
  parameter logic [7:0] OD_MASK    = 8'h0F
) (
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic [1:0]       regAddr,
  input logic [7:0]       regRdata,
  input logic [WIDTH-1:0] pldOe,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] openDrain,
  input logic [WIDTH-1:0] fastSlew
);
  logic [1:0] upCnt;
  logic [7:0] padInExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  always_comb begin
    padInExt = '0;
    padInExt[WIDTH-1:0] = padIn;
  end

  // R2
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> regRdata == 8'h00);

  // R7
  drive_kind_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (openDrain & fastSlew) == '0 && (openDrain & ~OD_MASK[WIDTH-1:0]) == '0);

  // R8
  od_release_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & openDrain & padOut) == '0);

  // R9
  pin_sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2 && regSel && regAddr == 2'd3) |-> regRdata == $past(padInExt, 2));

  generate
    if (USE_PLD_OE) begin : g_pldChk
      // R3
      pld_forces_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
        (pldOe & ~openDrain & ~padOe) == '0);
    end
    if (!HAS_CTRL) begin : g_noModeChk
      // R4
      no_mode_read_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regSel && regAddr == 2'd0) |-> regRdata == 8'h00);
    end
  endgenerate
endmodule

bind cfgIoPort cfgIoPortChk #(
  .WIDTH     (WIDTH),
  .HAS_CTRL  (HAS_CTRL),
  .USE_PLD_OE(USE_PLD_OE),
  .OD_MASK   (OD_MASK)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .pldOe    (pldOe),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .openDrain(openDrain),
  .fastSlew (fastSlew)
);

// File: tb/test_cfgIoPort.sv
module test_cfgIoPort;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selA = 1'b0, selB = 1'b0, regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0, addrBus = '0, pldOe = '0, padIn = '0;
  logic [7:0] rdA, poA, oeA, odA, fsA, rdB;
  logic [1:0] poB, oeB, odB, fsB;

  int checks = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgIoPort i_cfgIoPort (
    .clk(clk), .rstN(rstN), .regSel(selA), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(rdA), .addrBus(addrBus), .pldOe(pldOe),
    .padIn(padIn), .padOut(poA), .padOe(oeA), .openDrain(odA), .fastSlew(fsA)
  );

  cfgIoPort #(.WIDTH(2), .HAS_CTRL(1'b0), .USE_PLD_OE(1'b0), .OD_MASK(8'h03)) i_cfgIoPort_red (
    .clk(clk), .rstN(rstN), .regSel(selB), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(rdB), .addrBus(addrBus[1:0]), .pldOe(pldOe[1:0]),
    .padIn(padIn[1:0]), .padOut(poB), .padOe(oeB), .openDrain(odB), .fastSlew(fsB)
  );

  // behavioural model, index 0 = full port, 1 = reduced port
  logic [7:0] mMode [2], mDir [2], mDrv [2], mData [2];
  logic [7:0] histA [$];
  logic [7:0] histB [$];

  initial for (int v = 0; v < 2; v++) begin
    mMode[v] = 0; mDir[v] = 0; mDrv[v] = 0; mData[v] = 0;
  end

  function automatic logic [7:0] widthMask(int v);
    return (v == 0) ? 8'hFF : 8'h03;
  endfunction

  function automatic logic [7:0] odCap(int v);
    return (v == 0) ? 8'h0F : 8'h03;
  endfunction

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic calcExp(int v, output logic [7:0] eRd, output logic [7:0] ePo,
                         output logic [7:0] eOe, output logic [7:0] eOd, output logic [7:0] eFs);
    logic [7:0] m, want, seen;
    logic       sel;
    m    = widthMask(v);
    ePo  = ((mMode[v] & addrBus) | (~mMode[v] & mData[v])) & m;
    want = (v == 0) ? (mDir[v] | pldOe) : mDir[v];
    eOd  = mDrv[v] & odCap(v);
    eFs  = mDrv[v] & ~odCap(v) & m;
    eOe  = want & ~(eOd & ePo) & m;
    if (v == 0) seen = (histA.size() == 2) ? histA[0] : 8'h00;
    else        seen = (histB.size() == 2) ? histB[0] : 8'h00;
    sel  = (v == 0) ? selA : selB;
    eRd  = 8'h00;
    if (sel) begin
      case (regAddr)
        2'd0: eRd = mMode[v];
        2'd1: eRd = mDir[v];
        2'd2: eRd = mDrv[v];
        default: eRd = seen & m;
      endcase
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] eRd, ePo, eOe, eOd, eFs;
    if (!rstN) begin
      for (int v = 0; v < 2; v++) begin
        mMode[v] = 0; mDir[v] = 0; mDrv[v] = 0; mData[v] = 0;
      end
      histA.delete(); histB.delete();
    end else begin
      for (int v = 0; v < 2; v++) begin
        if (((v == 0) ? selA : selB) && regWr) begin
          case (regAddr)
            2'd0: if (v == 0) mMode[v] = regWdata;
            2'd1: mDir[v]  = regWdata & widthMask(v);
            2'd2: mDrv[v]  = regWdata & widthMask(v);
            default: mData[v] = regWdata & widthMask(v);
          endcase
        end
      end
      histA.push_back(padIn);
      histB.push_back(padIn & 8'h03);
      if (histA.size() > 2) void'(histA.pop_front());
      if (histB.size() > 2) void'(histB.pop_front());
    end
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      calcExp(0, eRd, ePo, eOe, eOd, eFs);
      cmp("R2 R9 full regRdata", rdA, eRd);
      cmp("R6 full padOut", poA, ePo);
      cmp("R3 R8 full padOe", oeA, eOe);
      cmp("R7 full openDrain", odA, eOd);
      cmp("R7 full fastSlew", fsA, eFs);
      calcExp(1, eRd, ePo, eOe, eOd, eFs);
      cmp("R4 R9 red regRdata", rdB, eRd);
      cmp("R6 red padOut", {6'd0, poB}, ePo);
      cmp("R5 R8 red padOe", {6'd0, oeB}, eOe);
      cmp("R7 red openDrain", {6'd0, odB}, eOd);
      cmp("R7 red fastSlew", {6'd0, fsB}, eFs);
    end
  end

  task automatic wrReg(logic a, logic b, logic [1:0] ofs, logic [7:0] d);
    @(negedge clk);
    selA = a; selB = b; regAddr = ofs; regWr = 1'b1; regWdata = d;
    @(negedge clk);
    selA = 1'b0; selB = 1'b0; regWr = 1'b0;
    #1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] lf = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    cmp("R1 padOe", oeA, 8'h00);
    cmp("R1 padOut", poA, 8'h00);
    cmp("R1 openDrain fastSlew", odA | fsA, 8'h00);
    cmp("R1 red padOe", {6'd0, oeB}, 8'h00);
    // R3 direction 0x07
    wrReg(1, 0, 2'd1, 8'h07);
    cmp("R3 dir 07", oeA, 8'h07);
    // R5 logic term widens full port only
    @(negedge clk); pldOe = 8'h33; #1;
    cmp("R3 pld or dir", oeA, 8'h37);
    cmp("R5 red ignores pld", {6'd0, oeB}, 8'h00);
    wrReg(0, 1, 2'd1, 8'h01);
    cmp("R5 red dir only", {6'd0, oeB}, 8'h01);
    // R6 mixed modes
    @(negedge clk); addrBus = 8'h3C;
    wrReg(1, 0, 2'd3, 8'hA5);
    wrReg(1, 0, 2'd0, 8'hF0);
    cmp("R6 mixed sources", poA, 8'h35);
    // R4 reduced port has no mode register
    wrReg(0, 1, 2'd0, 8'hFF);
    @(negedge clk); selB = 1'b1; regAddr = 2'd0; #1;
    cmp("R4 red mode reads 0", rdB, 8'h00);
    cmp("R4 red pins stay data", {6'd0, poB}, 8'h00);
    @(negedge clk); selB = 1'b0;
    // R7 R8 drive
    wrReg(1, 0, 2'd2, 8'hFF);
    cmp("R7 od pins", odA, 8'h0F);
    cmp("R7 slew pins", fsA, 8'hF0);
    cmp("R8 od release", oeA, 8'h32);
    // R9 pin read
    @(negedge clk); padIn = 8'h5A; selA = 1'b1; regAddr = 2'd3;
    @(negedge clk); padIn = 8'hC3; #1;
    cmp("R9 one edge later old", rdA, 8'h00);
    @(negedge clk); #1;
    cmp("R9 two edges later", rdA, 8'h5A);
    selA = 1'b0;
    // mixed random traffic checked against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      for (int k = 0; k < 32; k++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      selA = lf[0]; selB = lf[1]; regWr = lf[2] & lf[3];
      regAddr = lf[5:4]; regWdata = lf[15:8];
      pldOe = lf[23:16] & {8{lf[6]}}; padIn = lf[31:24]; addrBus = lf[23:16] ^ lf[15:8];
    end
    @(negedge clk); selA = 0; selB = 0; regWr = 0;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule